// File: doc/BRIEF.md
# GPIO Pad Interrupt Controller

This block gives software a register window over a small set of general-purpose pads. Each pad has two 32-bit configuration words. The first drives the pad's output value, selects the shared interrupt line for the pad, and reports the synchronised input level. The second chooses how the pad's input produces interrupt events and whether the input is inverted first. Pad configuration words are packed in groups of up to fifteen pads. Each group starts on a fresh 1 KiB boundary.

Each pad input passes through a two-flop synchroniser. It is then compared with its value one cycle earlier to find rising and falling edges, or used directly as a level. Each event sets one of sixteen shared status lines, chosen by the pad's 4-bit selector, so many pads can share one line. Software clears status lines by writing ones to them. A mask register picks which lines may raise the single combined interrupt output.

Top module: `gpio_pad_irq`

## Requirements
- R1: After reset, every register reads 0, `pad_out` is all 0 and `irq_out` is 0.
- R2: In the first word of a pad, bit 1 is stored and driven on that pad's `pad_out` bit, and bits 31:28 are stored as the line selector. Bit 0 reads the pad's input level two clock edges after the pad changes, and writes to it have no effect. All other bits read 0.
- R3: For pad p, the first word is at byte address 0x4400 + 1024*(p/15) + 8*(p%15) and the second word is at that address + 4. In the second word, bits 2:0 (trigger mode) and bit 6 (invert) are stored, and all other bits read 0.
- R4: Trigger mode 2 sets the selected line on a 0-to-1 transition of the detected input only.
- R5: Trigger mode 1 sets the selected line on a 1-to-0 transition only. Mode 3 sets it on either transition.
- R6: Trigger mode 4 sets the selected line on every cycle the detected input is 1, so a clear does not take effect while the level persists.
- R7: With bit 6 of the second word set, the input is inverted before detection. Changing this bit while the pad is steady creates no edge.
- R8: Trigger modes 0, 5, 6 and 7 never set a status line.
- R9: The status register at 0x300 holds 16 line bits in bits 15:0. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R10: When an event and a clear reach the same status bit in the same cycle, the bit stays set.
- R11: The mask register at 0x380 holds bits 15:0. `irq_out` is 1 exactly when some line has both its status and mask bits set, so a zero mask keeps `irq_out` at 0.
- R12: Reads of unmapped or misaligned addresses, or of pad slots beyond the last pad, return 0, and writes to them change no register.
- R13: Events from several pads whose selectors name the same line all set that one line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | NUM_PADS | Asynchronous pad inputs |
| pad_out | output | NUM_PADS | Output value driven to each pad |
| irq_out | output | 1 | Combined masked interrupt |

## Verification
The checker watches the status register on every cycle. It confirms that written ones clear bits that have no concurrent event, that an event always leaves its bit set even against a clear, and that untouched bits hold their value. It also checks that a zero mask silences the output, that mask writes land, and that a first-word write reaches the pad's output. Which trigger mode turns which input waveform into an event, the effect of inversion, selector routing across groups, and the address decoding of edge and unmapped slots can only be shown by the bench's pad stimulus and register reads.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;
  localparam int GROUP_PADS = 15;
  localparam logic [15:0] STAT_OFS = 16'h0300;
  localparam logic [15:0] MASK_OFS = 16'h0380;
  localparam logic [15:0] PAD_BASE = 16'h4400;

  localparam logic [2:0] TRIG_FALL  = 3'd1;
  localparam logic [2:0] TRIG_RISE  = 3'd2;
  localparam logic [2:0] TRIG_BOTH  = 3'd3;
  localparam logic [2:0] TRIG_LEVEL = 3'd4;

  // Byte address of the first configuration word of pad p.
  function automatic logic [15:0] pad_cfg_addr(input int p);
    int a;
    a = int'(PAD_BASE) + 1024 * (p / GROUP_PADS) + 8 * (p % GROUP_PADS);
    return a[15:0];
  endfunction

  // Event from the detected (inverted if asked) current and previous level.
  function automatic logic pad_event(input logic [2:0] mode, input logic cur,
                                     input logic prv);
    case (mode)
      TRIG_FALL:  return !cur && prv;
      TRIG_RISE:  return cur && !prv;
      TRIG_BOTH:  return cur != prv;
      TRIG_LEVEL: return cur;
      default:    return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/gpio_pad_sync.sv
`timescale 1ns/1ps
module gpio_pad_sync #(
  parameter int NUM_PADS = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [NUM_PADS-1:0] sync_q,
  output logic [NUM_PADS-1:0] prev_q
);
  logic [NUM_PADS-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pad_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end
endmodule

// File: rtl/gpio_pad_detect.sv
`timescale 1ns/1ps
module gpio_pad_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PADS  = 20,
  parameter int NUM_LINES = 16,
  localparam int SEL_W    = $clog2(NUM_LINES)
) (
  input  logic [NUM_PADS-1:0]            sync_q,
  input  logic [NUM_PADS-1:0]            prev_q,
  input  logic [NUM_PADS-1:0]            inv,
  input  logic [NUM_PADS-1:0][2:0]       mode,
  input  logic [NUM_PADS-1:0][SEL_W-1:0] sel,
  output logic [NUM_LINES-1:0]           set_vec
);
  logic [NUM_PADS-1:0] pad_evt;

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    // Both samples use the present invert bit, so toggling it makes no edge.
    assign pad_evt[p] = pad_event(mode[p], sync_q[p] ^ inv[p], prev_q[p] ^ inv[p]);
  end

  always_comb begin
    set_vec = '0;
    for (int p = 0; p < NUM_PADS; p++) begin
      if (pad_evt[p]) set_vec[sel[p]] = 1'b1;
    end
  end
endmodule

// File: rtl/gpio_irq_status.sv
`timescale 1ns/1ps
module gpio_irq_status #(
  parameter int NUM_LINES = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] set_vec,
  input  logic [NUM_LINES-1:0] clr_vec,
  input  logic                 mask_we,
  input  logic [NUM_LINES-1:0] mask_wdata,
  output logic [NUM_LINES-1:0] status_q,
  output logic [NUM_LINES-1:0] mask_q,
  output logic                 irq_out
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
    end else begin
      status_q <= (status_q & ~clr_vec) | set_vec;
      if (mask_we) mask_q <= mask_wdata;
    end
  end

  assign irq_out = |(status_q & mask_q);
endmodule

// File: rtl/gpio_pad_irq.sv
`timescale 1ns/1ps
module gpio_pad_irq
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PADS  = 20,
  parameter int NUM_LINES = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [15:0]         bus_addr,
  input  logic [31:0]         bus_wdata,
  input  logic                bus_we,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [NUM_PADS-1:0] pad_out,
  output logic                irq_out
);
  localparam int SEL_W = $clog2(NUM_LINES);

  logic [NUM_PADS-1:0]            sync_q, prev_q, hit0, hit1;
  logic [NUM_PADS-1:0]            out_q, inv_q;
  logic [NUM_PADS-1:0][2:0]       mode_q;
  logic [NUM_PADS-1:0][SEL_W-1:0] sel_q;
  logic [NUM_LINES-1:0]           set_vec, clr_vec, status_q, mask_q;
  logic                           mask_we;
  logic [11:0]                    unused_wdata;

  assign unused_wdata = bus_wdata[27:16];

  gpio_pad_sync #(.NUM_PADS(NUM_PADS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .sync_q(sync_q), .prev_q(prev_q)
  );

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_cfg
    assign hit0[p] = (bus_addr == pad_cfg_addr(p));
    assign hit1[p] = (bus_addr == pad_cfg_addr(p) + 16'd4);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        out_q[p]  <= 1'b0;
        sel_q[p]  <= '0;
        mode_q[p] <= '0;
        inv_q[p]  <= 1'b0;
      end else if (bus_we) begin
        if (hit0[p]) begin
          out_q[p] <= bus_wdata[1];
          sel_q[p] <= bus_wdata[31:32-SEL_W];
        end
        if (hit1[p]) begin
          mode_q[p] <= bus_wdata[2:0];
          inv_q[p]  <= bus_wdata[6];
        end
      end
    end
  end

  assign pad_out = out_q;

  gpio_pad_detect #(.NUM_PADS(NUM_PADS), .NUM_LINES(NUM_LINES)) u_det (
    .sync_q(sync_q), .prev_q(prev_q), .inv(inv_q), .mode(mode_q), .sel(sel_q),
    .set_vec(set_vec)
  );

  assign clr_vec = (bus_we && bus_addr == STAT_OFS) ? bus_wdata[NUM_LINES-1:0] : '0;
  assign mask_we = bus_we && (bus_addr == MASK_OFS);

  gpio_irq_status #(.NUM_LINES(NUM_LINES)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .mask_we(mask_we), .mask_wdata(bus_wdata[NUM_LINES-1:0]),
    .status_q(status_q), .mask_q(mask_q), .irq_out(irq_out)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == STAT_OFS) bus_rdata[NUM_LINES-1:0] = status_q;
    if (bus_addr == MASK_OFS) bus_rdata[NUM_LINES-1:0] = mask_q;
    for (int p = 0; p < NUM_PADS; p++) begin
      if (hit0[p]) bus_rdata = {sel_q[p], {(30-SEL_W){1'b0}}, out_q[p], sync_q[p]};
      if (hit1[p]) bus_rdata = {25'd0, inv_q[p], 3'd0, mode_q[p]};
    end
  end
endmodule

// File: rtl/gpio_pad_irq_chk.sv
`timescale 1ns/1ps
module gpio_pad_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PADS  = 20,
  parameter int NUM_LINES = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [15:0]          bus_addr,
  input logic [31:0]          bus_wdata,
  input logic                 bus_we,
  input logic [NUM_PADS-1:0]  pad_out,
  input logic                 irq_out,
  input logic [NUM_LINES-1:0] status_q,
  input logic [NUM_LINES-1:0] mask_q,
  input logic [NUM_LINES-1:0] set_vec,
  input logic [NUM_LINES-1:0] clr_vec
);
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec & ~set_vec)) |=> ((status_q & $past(clr_vec & ~set_vec)) == '0));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((status_q & ~$past(clr_vec | set_vec)) ==
               ($past(status_q) & ~$past(clr_vec | set_vec))));

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

  p_mask_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_out);

  p_mask_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == MASK_OFS) |=> (mask_q == $past(bus_wdata[NUM_LINES-1:0])));

  p_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == PAD_BASE) |=> (pad_out[0] == $past(bus_wdata[1])));
endmodule

bind gpio_pad_irq gpio_pad_irq_chk #(.NUM_PADS(NUM_PADS), .NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .pad_out(pad_out), .irq_out(irq_out), .status_q(status_q),
  .mask_q(mask_q), .set_vec(set_vec), .clr_vec(clr_vec)
);

// File: tb/sim_gpio_pad_irq.sv
`timescale 1ns/1ps
module sim_gpio_pad_irq;
  localparam int NP = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out;
  logic        irq_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_pad_irq #(.NUM_PADS(NP), .NUM_LINES(16)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
    .irq_out(irq_out)
  );

  // Row: {mode[2:0], invert, pad start, pad end, pending, after clear}
  localparam logic [7:0] VEC [0:12] = '{
    {3'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    {3'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {3'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    {3'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {3'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    {3'd3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    {3'd4, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
    {3'd4, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    {3'd4, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    {3'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {3'd5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {3'd7, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  function automatic logic [15:0] cfg_at(input int p);
    return 16'h4400 + 16'(p / 15) * 16'd1024 + 16'(p % 15) * 16'd8;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    logic [31:0] r;
    idle(4);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rd(16'h0300, r); check("R1 status", r, 32'h0);
    rd(16'h0380, r); check("R1 mask", r, 32'h0);
    rd(16'h4400, r); check("R1 cfg0", r, 32'h0);
    rd(16'h4404, r); check("R1 cfg1", r, 32'h0);
    check("R1 pad_out", 32'(pad_out), 32'h0);
    check("R1 irq", 32'(irq_out), 32'h0);

    // Trigger-mode table on pad 3, line 9
    wr(cfg_at(3), 32'h9000_0000);
    for (int i = 0; i < 13; i++) begin
      logic [2:0] md;
      logic iv, ps, pe, ep, ea;
      string tag;
      {md, iv, ps, pe, ep, ea} = VEC[i];
      tag = iv ? "R7" : (md == 3'd2) ? "R4" : (md == 3'd1 || md == 3'd3) ? "R5" :
            (md == 3'd4) ? "R6" : "R8";
      wr(cfg_at(3) + 16'd4, {25'd0, iv, 3'd0, md});
      pad_in[3] = ps;
      idle(6);
      wr(16'h0300, 32'h0000_FFFF);
      idle(1);
      pad_in[3] = pe;
      idle(6);
      rd(16'h0300, r); check($sformatf("%s pend row %0d", tag, i), r, {16'd0, 6'd0, ep, 9'd0});
      wr(16'h0300, 32'h0000_FFFF);
      rd(16'h0300, r); check($sformatf("%s post-clear row %0d", tag, i), r, {16'd0, 6'd0, ea, 9'd0});
    end
    pad_in[3] = 1'b0;
    wr(cfg_at(3) + 16'd4, 32'h0);
    idle(6);
    wr(16'h0300, 32'h0000_FFFF);

    // R2 first-word fields, R13 shared line across pads 16 and 17
    wr(cfg_at(16), 32'h5000_0002);
    rd(cfg_at(16), r); check("R2 cfg0 readback", r, 32'h5000_0002);
    check("R2 pad_out16", 32'(pad_out[16]), 32'h1);
    wr(cfg_at(16) + 16'd4, 32'h2);
    wr(cfg_at(17), 32'h5000_0001);
    rd(cfg_at(17), r); check("R2 input bit not writable", r, 32'h5000_0000);
    wr(cfg_at(17) + 16'd4, 32'h2);
    pad_in[17] = 1'b1;
    idle(4);
    rd(cfg_at(17), r); check("R2 input state", r, 32'h5000_0001);
    rd(16'h0300, r); check("R13 pad17 on line 5", r, 32'h20);
    wr(16'h0300, 32'h20);
    rd(16'h0300, r); check("R9 clear", r, 32'h0);
    pad_in[16] = 1'b1;
    idle(4);
    rd(16'h0300, r); check("R13 pad16 on line 5", r, 32'h20);

    // R11 mask and R9 write-zero
    check("R11 masked", 32'(irq_out), 32'h0);
    wr(16'h0380, 32'h20);
    check("R11 unmasked", 32'(irq_out), 32'h1);
    rd(16'h0380, r); check("R11 mask readback", r, 32'h20);
    wr(16'h0300, 32'h0);
    rd(16'h0300, r); check("R9 zero write keeps", r, 32'h20);
    wr(16'h0300, 32'hFFDF);
    rd(16'h0300, r); check("R9 other bits keep", r, 32'h20);
    wr(16'h0300, 32'h20);
    check("R11 irq drops", 32'(irq_out), 32'h0);
    wr(16'h0380, 32'h0);

    // R3 layout at group edges
    wr(cfg_at(14) + 16'd4, 32'hFFFF_FFF8);
    rd(16'h4474, r); check("R3 cfg1 pad14 fields", r, 32'h40);
    wr(16'h4800, 32'hC000_0000);
    rd(cfg_at(15), r); check("R3 pad15 at group 1", r, 32'hC000_0000);
    wr(16'h4820, 32'h2);
    check("R3 pad19 drive", 32'(pad_out[19]), 32'h1);

    // R12 unmapped and misaligned
    wr(16'h4478, 32'hFFFF_FFFF);
    rd(16'h4478, r); check("R12 slot 15 reads 0", r, 32'h0);
    rd(16'h4474, r); check("R12 neighbour kept", r, 32'h40);
    wr(16'h4802, 32'hFFFF_FFFF);
    rd(16'h4800, r); check("R12 misaligned ignored", r, 32'hC000_0000);
    rd(16'h4828, r); check("R12 pad 20 absent", r, 32'h0);
    wr(16'h0304, 32'hFFFF);
    rd(16'h0304, r); check("R12 near status", r, 32'h0);
    check("R12 pad_out unchanged", 32'(pad_out), 32'h0009_0000);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule